// File: doc/BRIEF.md
# Receive Frame Admission Filter

This block decides whether an incoming Ethernet frame is kept or dropped, and which receive events it raises. A receive datapath presents one frame summary per `frm_valid_i` pulse: the six destination address bytes, the total frame length in bytes and the current filter controls. One cycle later the block returns a single verdict: accept, or drop with the reason as an event pulse. It also returns the long-frame status flag and the byte count to write into the receive descriptor.

Address filtering covers broadcast, multicast and unicast frames. Unicast frames are compared against one stored station address, and a complement mode inverts that comparison. Size admission checks the frame against a programmable ceiling, held in the block and loaded through a one-word write port, and against the standard 1518-byte long-frame limit. Descriptor DMA and CRC generation stay outside the block.

Top module: `rxf_admit`

## Requirements
- R1: A frame whose length is below 14 bytes yields `done_o` with `accept_o`, `ev_early_o`, `ev_ovf_o`, `ev_long_o` and `long_o` all low.
- R2: Every frame of at least 14 bytes raises `ev_early_o`, whether it is later accepted or dropped.
- R3: A broadcast frame (all six destination bytes 0xFF) passes the address filter when `cmp_inv_i` or `acc_bcast_i` is set.
- R4: A multicast frame (bit 0 of the first destination byte set, not broadcast) passes when `cmp_inv_i` or `acc_mcast_i` is set.
- R5: A unicast frame passes when `acc_ucast_i` is set. Otherwise a match is `cam_cmp_en_i` AND `cam0_en_i` AND destination equal to the stored address; the frame passes on a match when `cmp_inv_i` is clear and on no match when it is set.
- R6: The stored address is `{cam_hi_i[31:0], cam_lo_i[31:16]}`, with the first destination byte (`frm_dest_i[47:40]`) compared to `cam_hi_i[31:24]`. `cam_lo_i[15:0]` is not used.
- R7: A frame that passes the filter, with length + 4 above the ceiling, is dropped with `ev_ovf_o`. This check takes priority over R8, and a frame failing the filter raises no size event.
- R8: A frame that passes the filter and the ceiling, with length + 4 above 1518, is dropped with `ev_long_o` when `long_ok_i` is clear. When `long_ok_i` is set it is accepted with `long_o` high.
- R9: For an accepted frame `rpt_len_o` is the length + 4 when `strip_crc_i` is clear and the length alone when it is set. It is 0 for a dropped frame.
- R10: The ceiling resets to 0x0800 and takes `ceil_d_i` on a clock edge with `ceil_we_i` high. It applies to frames from the following cycle on.
- R11: The outputs are valid for exactly one cycle, the cycle after `frm_valid_i`. At most one of `accept_o`, `ev_ovf_o` and `ev_long_o` is high, and all outputs are low when `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | Frame summary present this cycle |
| frm_dest_i | input | 48 | Destination address, first byte in [47:40] |
| frm_len_i | input | 16 | Frame length in bytes |
| cmp_inv_i | input | 1 | Complement-compare mode |
| acc_bcast_i | input | 1 | Accept broadcast |
| acc_mcast_i | input | 1 | Accept multicast |
| acc_ucast_i | input | 1 | Accept all unicast |
| cam_cmp_en_i | input | 1 | Enable the address comparison |
| cam0_en_i | input | 1 | Address entry 0 valid |
| cam_hi_i | input | 32 | Stored address bytes 0 to 3 |
| cam_lo_i | input | 32 | Stored address bytes 4 and 5 in [31:16] |
| ceil_we_i | input | 1 | Load the frame ceiling |
| ceil_d_i | input | 16 | New frame ceiling in bytes |
| long_ok_i | input | 1 | Accept frames above 1518 bytes |
| strip_crc_i | input | 1 | Report length without the CRC bytes |
| done_o | output | 1 | Verdict valid |
| accept_o | output | 1 | Frame accepted |
| ev_early_o | output | 1 | Length/type field seen event |
| ev_ovf_o | output | 1 | Above-ceiling drop event |
| ev_long_o | output | 1 | Too-long drop event |
| long_o | output | 1 | Accepted frame is above the standard limit |
| rpt_len_o | output | 16 | Length reported to the descriptor |

## Verification
The bench builds the block with its default parameters: a 16-bit length, a 1518-byte standard limit and a 0x0800 reset ceiling. Because the reset ceiling lies above the standard limit, lengths just past 1518 reach the long-frame path and lengths just past 2044 reach the ceiling path without a write. Reloading the ceiling to 100 and to 1000 then moves it below the standard limit, which exposes the ceiling-before-long priority and the boundary at exactly ceiling minus 4.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned MIN_LEN    = 14;
  localparam int unsigned CRC_BYTES  = 4;

  typedef struct packed {
    logic done;
    logic accept;
    logic early;
    logic ovf;
    logic lng_ev;
    logic lng;
  } verdict_t;
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
(
  input  logic [ADDR_W-1:0] dest_i,
  output logic              bcast_o,
  output logic              mcast_o
);
  logic [ADDR_BYTES-1:0] byte_ff;

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    assign byte_ff[b] = &dest_i[8*b +: 8];
  end

  assign bcast_o = &byte_ff;
  // group bit is the LSB of the first byte on the wire
  assign mcast_o = dest_i[ADDR_W-8] & ~bcast_o;
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter
  import rxf_pkg::*;
(
  input  logic [ADDR_W-1:0] dest_i,
  input  logic              bcast_i,
  input  logic              mcast_i,
  input  logic              cmp_inv_i,
  input  logic              acc_bcast_i,
  input  logic              acc_mcast_i,
  input  logic              acc_ucast_i,
  input  logic              cam_cmp_en_i,
  input  logic              cam0_en_i,
  input  logic [31:0]       cam_hi_i,
  input  logic [31:0]       cam_lo_i,
  output logic              pass_o
);
  logic [ADDR_W-1:0] cam_addr;
  logic              hit;

  assign cam_addr = {cam_hi_i, cam_lo_i[31:16]};
  assign hit      = cam_cmp_en_i & cam0_en_i & (dest_i == cam_addr);

  always_comb begin
    if (bcast_i)      pass_o = cmp_inv_i | acc_bcast_i;
    else if (mcast_i) pass_o = cmp_inv_i | acc_mcast_i;
    else if (acc_ucast_i) pass_o = 1'b1;
    else              pass_o = hit ^ cmp_inv_i;
  end
endmodule

// File: rtl/rxf_size.sv
module rxf_size
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned STD_MAX = 1518
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] ceil_i,
  input  logic             strip_crc_i,
  output logic             over_ceil_o,
  output logic             over_std_o,
  output logic [LEN_W-1:0] rpt_len_o
);
  localparam logic [LEN_W:0] CRC_EXT = (LEN_W+1)'(CRC_BYTES);
  localparam logic [LEN_W:0] STD_EXT = (LEN_W+1)'(STD_MAX);

  logic [LEN_W:0] wire_len;

  assign wire_len    = {1'b0, len_i} + CRC_EXT;
  assign over_ceil_o = wire_len > {1'b0, ceil_i};
  assign over_std_o  = wire_len > STD_EXT;
  assign rpt_len_o   = strip_crc_i ? len_i : wire_len[LEN_W-1:0];
endmodule

// File: rtl/rxf_admit.sv
module rxf_admit
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned STD_MAX  = 1518,
  parameter int unsigned CEIL_RST = 'h0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic [47:0]       frm_dest_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              cmp_inv_i,
  input  logic              acc_bcast_i,
  input  logic              acc_mcast_i,
  input  logic              acc_ucast_i,
  input  logic              cam_cmp_en_i,
  input  logic              cam0_en_i,
  input  logic [31:0]       cam_hi_i,
  input  logic [31:0]       cam_lo_i,
  input  logic              ceil_we_i,
  input  logic [LEN_W-1:0]  ceil_d_i,
  input  logic              long_ok_i,
  input  logic              strip_crc_i,
  output logic              done_o,
  output logic              accept_o,
  output logic              ev_early_o,
  output logic              ev_ovf_o,
  output logic              ev_long_o,
  output logic              long_o,
  output logic [LEN_W-1:0]  rpt_len_o
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] ceil_q;
  logic             bcast, mcast, pass;
  logic             over_ceil, over_std;
  logic [LEN_W-1:0] len_calc;
  verdict_t         vd_d, vd_q;
  logic [LEN_W-1:0] len_d, len_q;

  rxf_classify u_cls (
    .dest_i  (frm_dest_i),
    .bcast_o (bcast),
    .mcast_o (mcast)
  );

  rxf_filter u_flt (
    .dest_i       (frm_dest_i),
    .bcast_i      (bcast),
    .mcast_i      (mcast),
    .cmp_inv_i    (cmp_inv_i),
    .acc_bcast_i  (acc_bcast_i),
    .acc_mcast_i  (acc_mcast_i),
    .acc_ucast_i  (acc_ucast_i),
    .cam_cmp_en_i (cam_cmp_en_i),
    .cam0_en_i    (cam0_en_i),
    .cam_hi_i     (cam_hi_i),
    .cam_lo_i     (cam_lo_i),
    .pass_o       (pass)
  );

  rxf_size #(.LEN_W(LEN_W), .STD_MAX(STD_MAX)) u_size (
    .len_i       (frm_len_i),
    .ceil_i      (ceil_q),
    .strip_crc_i (strip_crc_i),
    .over_ceil_o (over_ceil),
    .over_std_o  (over_std),
    .rpt_len_o   (len_calc)
  );

  // drop order: short, filter, ceiling, long limit
  always_comb begin
    logic seen, kept;
    seen          = frm_valid_i & (frm_len_i >= MIN_L);
    kept          = seen & pass;
    vd_d.done     = frm_valid_i;
    vd_d.early    = seen;
    vd_d.ovf      = kept & over_ceil;
    vd_d.lng_ev   = kept & ~over_ceil & over_std & ~long_ok_i;
    vd_d.accept   = kept & ~over_ceil & (~over_std | long_ok_i);
    vd_d.lng      = vd_d.accept & over_std;
    len_d         = vd_d.accept ? len_calc : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ceil_q <= LEN_W'(CEIL_RST);
      vd_q   <= '0;
      len_q  <= '0;
    end else begin
      if (ceil_we_i) ceil_q <= ceil_d_i;
      vd_q  <= vd_d;
      len_q <= len_d;
    end
  end

  assign done_o     = vd_q.done;
  assign accept_o   = vd_q.accept;
  assign ev_early_o = vd_q.early;
  assign ev_ovf_o   = vd_q.ovf;
  assign ev_long_o  = vd_q.lng_ev;
  assign long_o     = vd_q.lng;
  assign rpt_len_o  = len_q;
endmodule

// File: rtl/rxf_admit_chk.sv
module rxf_admit_chk
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frm_valid_i,
  input logic [LEN_W-1:0] frm_len_i,
  input logic             strip_crc_i,
  input logic             done_o,
  input logic             accept_o,
  input logic             ev_early_o,
  input logic             ev_ovf_o,
  input logic             ev_long_o,
  input logic             long_o,
  input logic [LEN_W-1:0] rpt_len_o
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] CRC_L = LEN_W'(CRC_BYTES);

  a_r1_short_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && frm_len_i < MIN_L |=>
      done_o && !accept_o && !ev_early_o && !ev_ovf_o && !ev_long_o && !long_o);

  a_r2_early_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i && frm_len_i >= MIN_L |=> ev_early_o);

  a_r8_long_flag_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_o |-> accept_o);

  a_r9_len_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i ##1 accept_o |->
      rpt_len_o == ($past(strip_crc_i) ? $past(frm_len_i) : $past(frm_len_i) + CRC_L));

  a_r9_len_zero_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> rpt_len_o == '0);

  a_r11_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> done_o);

  a_r11_done_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> !done_o);

  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept_o, ev_ovf_o, ev_long_o}));

  a_r11_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(accept_o || ev_early_o || ev_ovf_o || ev_long_o || long_o));
endmodule

bind rxf_admit rxf_admit_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frm_valid_i (frm_valid_i),
  .frm_len_i   (frm_len_i),
  .strip_crc_i (strip_crc_i),
  .done_o      (done_o),
  .accept_o    (accept_o),
  .ev_early_o  (ev_early_o),
  .ev_ovf_o    (ev_ovf_o),
  .ev_long_o   (ev_long_o),
  .long_o      (long_o),
  .rpt_len_o   (rpt_len_o)
);

// File: tb/rxf_admit_test.sv
module rxf_admit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [47:0] dest = '0;
  logic [15:0] len = '0;
  logic        inv = 0, abc = 0, amc = 0, auc = 0, cmpen = 0, en0 = 0;
  logic [31:0] cam_hi = 32'h0211_2233, cam_lo = 32'h4455_ABCD;
  logic        cwe = 0;
  logic [15:0] cd = '0;
  logic        lok = 0, strip = 0;
  logic        done, acc, early, ovf, lev, lng;
  logic [15:0] rlen;

  always #4 clk = ~clk;

  rxf_admit uut (
    .clk_i(clk), .rst_ni(rst_n), .frm_valid_i(valid), .frm_dest_i(dest),
    .frm_len_i(len), .cmp_inv_i(inv), .acc_bcast_i(abc), .acc_mcast_i(amc),
    .acc_ucast_i(auc), .cam_cmp_en_i(cmpen), .cam0_en_i(en0),
    .cam_hi_i(cam_hi), .cam_lo_i(cam_lo), .ceil_we_i(cwe), .ceil_d_i(cd),
    .long_ok_i(lok), .strip_crc_i(strip), .done_o(done), .accept_o(acc),
    .ev_early_o(early), .ev_ovf_o(ovf), .ev_long_o(lev), .long_o(lng),
    .rpt_len_o(rlen)
  );

  typedef struct {
    logic [5:0]  flags;  // accept, early, ovf, long event, long flag, done
    logic [15:0] len;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   ceil_m = 'h800;

  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC  = 48'h0100_5E00_0001;
  localparam logic [47:0] UC  = 48'h0211_2233_4455;
  localparam logic [47:0] UCX = 48'h0211_2233_4456;
  localparam logic [47:0] UC0 = 48'h0411_2233_4455;

  function automatic exp_t model(logic [47:0] d, int l, string r);
    exp_t e;
    bit   pass, hit;
    e.req = r; e.len = '0; e.flags = 6'b000001;
    if (l < 14) return e;
    e.flags[4] = 1;
    hit = cmpen && en0 && d == {cam_hi, cam_lo[31:16]};
    if (d == BC)       pass = inv || abc;
    else if (d[40])    pass = inv || amc;
    else if (auc)      pass = 1;
    else               pass = inv ? !hit : hit;
    if (!pass) return e;
    if (l + 4 > ceil_m) e.flags[3] = 1;
    else if (l + 4 > 1518 && !lok) e.flags[2] = 1;
    else begin
      e.flags[5] = 1;
      e.flags[1] = (l + 4 > 1518);
      e.len = strip ? 16'(l) : 16'(l + 4);
    end
    return e;
  endfunction

  task automatic send(logic [47:0] d, int l, string r);
    @(negedge clk);
    dest = d; len = 16'(l); valid = 1;
    q.push_back(model(d, l, r));
    @(negedge clk);
    valid = 0;
  endtask

  task automatic set_ceil(int v);
    @(negedge clk);
    cwe = 1; cd = 16'(v);
    @(negedge clk);
    cwe = 0; ceil_m = v;
  endtask

  // monitor: pops one expected item per verdict
  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [5:0] got;
      got = {acc, early, ovf, lev, lng, done};
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected verdict flags=%b len=%0d expected none", got, rlen);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (got !== e.flags || rlen !== e.len) begin
          errors++;
          $display("FAIL %s flags=%b len=%0d expected flags=%b len=%0d",
                   e.req, got, rlen, e.flags, e.len);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if ({done, acc, early, ovf, lev, lng} !== 6'b0 || rlen !== 16'd0) begin
      errors++;
      $display("FAIL R11 reset outputs=%b len=%0d expected 0", {done, acc, early, ovf, lev, lng}, rlen);
    end

    // R1 short frames, R2 early event at 14
    abc = 1;
    send(BC, 13, "R1 short");
    send(BC, 0, "R1 zero");
    send(BC, 14, "R2 minimum");
    // R3 broadcast
    abc = 0;
    send(BC, 64, "R3 bcast off");
    abc = 1;
    send(BC, 64, "R3 bcast on");
    abc = 0; inv = 1;
    send(BC, 64, "R3 bcast via complement");
    inv = 0;
    // R4 multicast
    send(MC, 64, "R4 mcast off");
    amc = 1;
    send(MC, 64, "R4 mcast on");
    amc = 0; inv = 1;
    send(MC, 80, "R4 mcast via complement");
    inv = 0;
    // R5 unicast
    send(UC, 64, "R5 compare off");
    cmpen = 1;
    send(UC, 64, "R5 entry disabled");
    en0 = 1;
    send(UC, 64, "R5 match");
    send(UCX, 64, "R5 mismatch");
    inv = 1;
    send(UC, 64, "R5 complement match");
    send(UCX, 64, "R5 complement mismatch");
    inv = 0; auc = 1;
    send(UCX, 64, "R5 accept all unicast");
    auc = 0;
    // R6 byte layout
    send(UC0, 64, "R6 first byte differs");
    cam_lo = 32'h4455_1234;
    send(UC, 64, "R6 low half ignored");
    // R8 long limit, R7 reset ceiling, R10 reset value
    abc = 1;
    send(BC, 1514, "R8 at standard limit");
    send(BC, 1515, "R8 long dropped");
    lok = 1;
    send(BC, 1515, "R8 long accepted");
    send(BC, 2044, "R10 at reset ceiling");
    send(BC, 2045, "R7 over reset ceiling");
    // R10 reload, R7 priority
    set_ceil(100);
    send(BC, 96, "R10 at new ceiling");
    send(BC, 97, "R7 over new ceiling");
    abc = 0;
    send(BC, 97, "R7 filter before ceiling");
    abc = 1; lok = 0;
    set_ceil(1000);
    send(BC, 1200, "R7 ceiling before long limit");
    // R9 stripping
    strip = 1;
    send(BC, 64, "R9 strip crc");
    send(UCX, 64, "R9 dropped length zero");
    strip = 0;
    send(BC, 200, "R9 with crc");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing verdicts=%0d expected 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule